// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

The block keeps time of day and a calendar date in byte registers and moves them forward by one second each time its `tick` input is pulsed. Seconds, minutes, hours, day of week, day of month, month and a two-digit year each sit at a fixed register index. Three more bytes hold an alarm time, which is compared with the live time after every advance.

A host reads and writes every register through a byte-wide port. The read data is combinational. A write lands on the next clock edge. A control byte holds three mode bits:
- one chooses BCD or plain binary numbers;
- one chooses 12-hour or 24-hour counting;
- one freezes the count while the host loads a new time.

The modes can change at run time. The stored bytes are then read in the new format, so the host is expected to rewrite the time after a change. Leap years are handled for years 00 to 99 as every year divisible by four.

Top module: `rtc_calendar`

## Requirements
- R1: After reset:
  - seconds, minutes, hours, year and all three alarm bytes read 0x00;
  - day of week, day of month and month read 0x01;
  - the control byte (index 11) reads 0x02, meaning BCD and 24-hour mode.
- R2: Register indices are:
  - 0 seconds, 1 seconds alarm;
  - 2 minutes, 3 minutes alarm;
  - 4 hours, 5 hours alarm;
  - 6 day of week, 7 day of month, 8 month, 9 year;
  - 11 control.

  A write stores its byte and a read returns it. Index 10 and indices 12 to 15 read 0x00 and ignore writes.
- R3: With control bit 2 clear, every time and date byte counts in BCD. Seconds and minutes go from 59 to 00 and carry into the next field. Hours in 24-hour mode go from 23 to 00 and carry into the date.
- R4: With control bit 2 set, the same fields count in plain binary; for example seconds 0x3B is followed by 0x00 with a minute carry.
- R5: With control bit 1 clear, hours count 12, 1, 2 … 11, and bit 7 of the hours byte is the PM flag. The PM flag toggles on the step from 11 to 12. The step from 11 PM to 12 AM advances the date.
- R6: Day of week counts 1 to 7 and returns to 1 when the date advances.
- R7: Day of month returns to 1 after the month's last day:
  - 30 days for months 4, 6, 9 and 11;
  - 29 days for month 2 when the year is divisible by 4, otherwise 28;
  - 31 days for every other month.

  Month 12 returns to 1 and advances the year. Year 99 returns to 00.
- R8: While control bit 7 is set, ticks change no time register and raise no alarm.
- R9: `alarm_pulse` is high for exactly the one cycle after an advancing tick, and only when each alarm byte either equals its live field or has both bits 7 and 6 set (a wildcard).
- R10: A host write in the same cycle as a tick stores the written byte, and that tick is dropped, so no field advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle pulse, once per second |
| wr_en | input | 1 | Host write strobe |
| addr | input | 4 | Register index for read and write |
| wdata | input | 8 | Host write data |
| rdata | output | 8 | Register contents at `addr` |
| alarm_pulse | output | 1 | One-cycle alarm match after an update |

## Verification
The assertions check these properties on every cycle:
- the seconds byte holds still without a tick or a write, and holds still under a tick while frozen;
- a seconds write lands the next cycle;
- an alarm pulse is always preceded by an advancing tick.

The carry chain, the month lengths, leap years, the 12-hour PM toggling, the BCD and binary encodings and the wildcard alarm are shown only by the bench's scenarios. In those scenarios, loaded times near rollovers are compared field by field against a calendar model kept in the bench.

// File: rtl/rtc_calendar.sv
module rtc_calendar #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          alarm_pulse
);
  logic [7:0] sec_q, sal_q, min_q, mal_q, hr_q, hal_q, dow_q, dom_q, mon_q, yr_q, ctrl_q;
  logic       upd_q;

  function automatic logic [6:0] dec(input logic [7:0] b, input logic bin);
    logic [6:0] t;
    t = 7'(b[7:4]) * 7'd10 + 7'(b[3:0]);
    return bin ? b[6:0] : t;
  endfunction

  function automatic logic [7:0] enc(input logic [6:0] v, input logic bin);
    logic [6:0] hi, lo;
    hi = v / 7'd10;
    lo = v % 7'd10;
    return bin ? {1'b0, v} : {hi[3:0], lo[3:0]};
  endfunction

  function automatic logic hit(input logic [7:0] a, input logic [7:0] t);
    return (a[7:6] == 2'b11) || (a == t);
  endfunction

  wire bin = ctrl_q[2];
  wire h24 = ctrl_q[1];
  wire adv = tick & ~ctrl_q[7] & ~wr_en;

  logic [6:0] s, m, hv, dw, dd, mo, yr;
  logic [6:0] ns, nm, nh, ndw, ndd, nmo, nyr, mlen;
  logic       pm, npm, c_h, c_d, c_mo, c_y, c_m;

  always_comb begin
    s  = dec(sec_q, bin);
    m  = dec(min_q, bin);
    hv = dec(hr_q & 8'h7F, bin);
    pm = hr_q[7];
    dw = dec(dow_q, bin);
    dd = dec(dom_q, bin);
    mo = dec(mon_q, bin);
    yr = dec(yr_q, bin);
    case (mo)
      7'd2:                      mlen = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11:   mlen = 7'd30;
      default:                   mlen = 7'd31;
    endcase

    c_m = s >= 7'd59;
    ns  = c_m ? 7'd0 : s + 7'd1;
    c_h = c_m && (m >= 7'd59);
    nm  = c_m ? (c_h ? 7'd0 : m + 7'd1) : m;

    nh  = hv;
    npm = pm;
    c_d = 1'b0;
    if (c_h) begin
      if (h24) begin
        c_d = hv >= 7'd23;
        nh  = c_d ? 7'd0 : hv + 7'd1;
        npm = 1'b0;
      end else if (hv == 7'd11) begin
        nh  = 7'd12;
        npm = ~pm;
        c_d = pm;
      end else if (hv >= 7'd12) begin
        nh  = 7'd1;
      end else begin
        nh  = hv + 7'd1;
      end
    end

    ndw  = dw;
    ndd  = dd;
    c_mo = 1'b0;
    if (c_d) begin
      ndw  = (dw >= 7'd7) ? 7'd1 : dw + 7'd1;
      c_mo = dd >= mlen;
      ndd  = c_mo ? 7'd1 : dd + 7'd1;
    end
    c_y = c_mo && (mo >= 7'd12);
    nmo = c_mo ? (c_y ? 7'd1 : mo + 7'd1) : mo;
    nyr = c_y ? ((yr >= 7'd99) ? 7'd0 : yr + 7'd1) : yr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {sec_q, sal_q, min_q, mal_q, hr_q, hal_q, yr_q} <= '0;
      dow_q  <= 8'h01;
      dom_q  <= 8'h01;
      mon_q  <= 8'h01;
      ctrl_q <= 8'h02;
      upd_q  <= 1'b0;
    end else begin
      upd_q <= adv;
      if (wr_en) begin
        case (addr)
          AW'(0):  sec_q  <= wdata;
          AW'(1):  sal_q  <= wdata;
          AW'(2):  min_q  <= wdata;
          AW'(3):  mal_q  <= wdata;
          AW'(4):  hr_q   <= wdata;
          AW'(5):  hal_q  <= wdata;
          AW'(6):  dow_q  <= wdata;
          AW'(7):  dom_q  <= wdata;
          AW'(8):  mon_q  <= wdata;
          AW'(9):  yr_q   <= wdata;
          AW'(11): ctrl_q <= wdata;
          default: ;
        endcase
      end else if (adv) begin
        sec_q <= enc(ns, bin);
        min_q <= enc(nm, bin);
        hr_q  <= enc(nh, bin) | {npm & ~h24, 7'b0};
        dow_q <= enc(ndw, bin);
        dom_q <= enc(ndd, bin);
        mon_q <= enc(nmo, bin);
        yr_q  <= enc(nyr, bin);
      end
    end
  end

  always_comb begin
    case (addr)
      AW'(0):  rdata = sec_q;
      AW'(1):  rdata = sal_q;
      AW'(2):  rdata = min_q;
      AW'(3):  rdata = mal_q;
      AW'(4):  rdata = hr_q;
      AW'(5):  rdata = hal_q;
      AW'(6):  rdata = dow_q;
      AW'(7):  rdata = dom_q;
      AW'(8):  rdata = mon_q;
      AW'(9):  rdata = yr_q;
      AW'(11): rdata = ctrl_q;
      default: rdata = 8'h00;
    endcase
  end

  assign alarm_pulse = upd_q & hit(sal_q, sec_q) & hit(mal_q, min_q) & hit(hal_q, hr_q);
endmodule

// File: rtl/rtc_calendar_chk.sv
module rtc_calendar_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       wr_en,
  input logic [3:0] addr,
  input logic [7:0] wdata,
  input logic [7:0] ctrl,
  input logic [7:0] sec,
  input logic       alarm_pulse
);
  // R3
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(sec));

  // R8
  set_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && ctrl[7] && !wr_en) |=> $stable(sec));

  // R9
  alarm_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_pulse |-> $past(tick && !ctrl[7] && !wr_en));

  // R10
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 4'd0) |=> (sec == $past(wdata)));
endmodule

bind rtc_calendar rtc_calendar_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
  .wdata(wdata), .ctrl(ctrl_q), .sec(sec_q), .alarm_pulse(alarm_pulse)
);

// File: tb/sim_rtc_calendar.sv
module sim_rtc_calendar;
  logic clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0, rdata;
  logic alarm_pulse;
  int checks = 0, errors = 0;
  bit done = 0;

  int ms, mm, mh, dw, dd, mo, yr;
  bit bcd, h24;
  logic [7:0] sal, mal, hal;

  rtc_calendar u0 (.clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .addr(addr),
                   .wdata(wdata), .rdata(rdata), .alarm_pulse(alarm_pulse));

  always #10 clk = ~clk;

  function automatic logic [7:0] fmt(int v, bit b);
    return b ? 8'(((v / 10) << 4) | (v % 10)) : 8'(v);
  endfunction

  function automatic logic [7:0] hrenc(int h, bit b, bit t24);
    int h12;
    if (t24) return fmt(h, b);
    h12 = (h % 12 == 0) ? 12 : h % 12;
    return fmt(h12, b) | ((h >= 12) ? 8'h80 : 8'h00);
  endfunction

  function automatic int mdays(int mon, int y);
    if (mon == 2) return (y % 4 == 0) ? 29 : 28;
    if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
    return 31;
  endfunction

  function automatic bit amatch(logic [7:0] a, logic [7:0] t);
    return (a[7:6] == 2'b11) || (a == t);
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = 4'(a); wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(int a, output logic [7:0] d);
    addr = 4'(a);
    #1 d = rdata;
  endtask

  task automatic model_step();
    ms++;
    if (ms == 60) begin
      ms = 0; mm++;
      if (mm == 60) begin
        mm = 0; mh++;
        if (mh == 24) begin
          mh = 0;
          dw = (dw == 7) ? 1 : dw + 1;
          dd++;
          if (dd > mdays(mo, yr)) begin
            dd = 1; mo++;
            if (mo == 13) begin mo = 1; yr = (yr + 1) % 100; end
          end
        end
      end
    end
  endtask

  task automatic load(bit b, bit t24, int h, int mi, int se, int w, int d, int mn, int y);
    bcd = b; h24 = t24; ms = se; mm = mi; mh = h; dw = w; dd = d; mo = mn; yr = y;
    wr(11, {5'b0, ~b, t24, 1'b0});
    wr(0, fmt(ms, bcd)); wr(2, fmt(mm, bcd)); wr(4, hrenc(mh, bcd, h24));
    wr(6, fmt(dw, bcd)); wr(7, fmt(dd, bcd)); wr(8, fmt(mo, bcd)); wr(9, fmt(yr, bcd));
  endtask

  task automatic set_alarm(logic [7:0] s, logic [7:0] m, logic [7:0] h);
    sal = s; mal = m; hal = h;
    wr(1, s); wr(3, m); wr(5, h);
  endtask

  task automatic check_all(string req);
    logic [7:0] v;
    rd(0, v); chk(req, v, fmt(ms, bcd));
    rd(2, v); chk(req, v, fmt(mm, bcd));
    rd(4, v); chk(req, v, hrenc(mh, bcd, h24));
    rd(6, v); chk(req, v, fmt(dw, bcd));
    rd(7, v); chk(req, v, fmt(dd, bcd));
    rd(8, v); chk(req, v, fmt(mo, bcd));
    rd(9, v); chk(req, v, fmt(yr, bcd));
  endtask

  task automatic do_tick(bit frozen);
    bit exp;
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
    if (!frozen) model_step();
    exp = !frozen && amatch(sal, fmt(ms, bcd)) && amatch(mal, fmt(mm, bcd)) &&
          amatch(hal, hrenc(mh, bcd, h24));
    chk("R9 pulse", 8'(alarm_pulse), 8'(exp));
    @(negedge clk);
    chk("R9 single cycle", 8'(alarm_pulse), 8'h00);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    sal = 0; mal = 0; hal = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    bcd = 1; h24 = 1; ms = 0; mm = 0; mh = 0; dw = 1; dd = 1; mo = 1; yr = 0;
    check_all("R1");
    rd(1, v); chk("R1 alarm", v, 8'h00);
    rd(3, v); chk("R1 alarm", v, 8'h00);
    rd(5, v); chk("R1 alarm", v, 8'h00);
    rd(11, v); chk("R1 control", v, 8'h02);

    // R2 map and unused indices
    wr(1, 8'h45); rd(1, v); chk("R2 readback", v, 8'h45);
    wr(10, 8'h5A); rd(10, v); chk("R2 unused 10", v, 8'h00);
    wr(13, 8'hA5); rd(13, v); chk("R2 unused 13", v, 8'h00);
    check_all("R2 unused write side effect");
    set_alarm(8'h01, 8'h01, 8'h01);

    // R3 R6 R7 full BCD rollover
    load(1, 1, 23, 59, 59, 7, 31, 12, 99);
    do_tick(0); check_all("R3 R6 R7 year wrap");
    // R4 binary
    load(0, 1, 5, 10, 59, 3, 15, 6, 40);
    do_tick(0); check_all("R4 binary");
    rd(0, v); chk("R4 sec", v, 8'h00);
    rd(2, v); chk("R4 min", v, 8'h0B);
    // R5 12-hour
    load(1, 0, 11, 59, 59, 2, 10, 3, 20);
    do_tick(0); rd(4, v); chk("R5 11AM to 12PM", v, 8'h92);
    load(1, 0, 12, 59, 59, 2, 10, 3, 20);
    do_tick(0); rd(4, v); chk("R5 12PM to 1PM", v, 8'h81);
    load(1, 0, 23, 59, 59, 2, 10, 3, 20);
    do_tick(0); rd(4, v); chk("R5 11PM to 12AM", v, 8'h12);
    check_all("R5 date advance");
    // R7 month lengths
    load(1, 1, 23, 59, 59, 1, 28, 2, 24);
    do_tick(0); check_all("R7 leap Feb");
    rd(7, v); chk("R7 Feb 29", v, 8'h29);
    load(1, 1, 23, 59, 59, 1, 28, 2, 23);
    do_tick(0); rd(8, v); chk("R7 Feb 28 to Mar", v, 8'h03);
    load(1, 1, 23, 59, 59, 1, 30, 4, 23);
    do_tick(0); rd(8, v); chk("R7 Apr 30 to May", v, 8'h05);
    // R8 freeze
    load(1, 1, 10, 20, 30, 4, 5, 6, 7);
    set_alarm(8'hC0, 8'hC0, 8'hC0);
    wr(11, 8'h82);
    do_tick(1); check_all("R8 frozen");
    wr(11, 8'h02);
    do_tick(0); check_all("R9 wildcard after unfreeze");
    // R10 write wins over tick
    @(negedge clk); tick = 1; wr_en = 1; addr = 4'd2; wdata = 8'h33;
    @(negedge clk); tick = 0; wr_en = 0;
    chk("R10 no pulse", 8'(alarm_pulse), 8'h00);
    mm = 33; check_all("R10 tick dropped");
    // R9 exact match
    load(1, 1, 0, 0, 4, 1, 1, 1, 0);
    set_alarm(8'h05, 8'h00, 8'h00);
    do_tick(0);
    do_tick(0);
    set_alarm(8'hC0, 8'h01, 8'h00);
    do_tick(0);

    // random mixed
    for (int i = 0; i < 40; i++) begin
      int h, mon;
      bit b, t;
      b = ($urandom % 2) == 0; t = ($urandom % 2) == 0;
      h = $urandom % 24; mon = 1 + $urandom % 12;
      load(b, t, h, 58 + $urandom % 2, 56 + $urandom % 4, 1 + $urandom % 7,
           1 + int'($urandom % 32'(mdays(mon, 0))), mon, $urandom % 100);
      case ($urandom % 3)
        0: set_alarm(8'hC0, fmt(mm, bcd), hrenc(mh, bcd, h24));
        1: set_alarm(fmt(59, bcd), 8'hC0, 8'hC0);
        default: set_alarm(8'hC0, 8'hC0, 8'hFF);
      endcase
      for (int k = 0; k < 1 + int'($urandom % 5); k++) do_tick(0);
      check_all("R3 R4 R5 R6 R7 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule